// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in a translation cache. It takes the address, whether the access is a store, and the base address of the top-level directory. It then makes two dependent reads through a simple memory port. The first read fetches a directory entry, whose frame number locates a second-level table. The second read fetches the table entry, whose frame number locates the data page. The walker returns the physical address and the page permissions, or it reports a page fault.

When the access is allowed, the walker keeps the hardware-maintained flags of the final entry up to date. The reference flag is set on every permitted access, and the dirty flag is also set on a store. The entry is written back only when one of these flags actually changes. The done pulse follows that write.

Every memory transaction uses a request/valid handshake. The walker holds its request until the valid strobe arrives, so it works with any memory latency.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done` and `mem_req` are all low.
- R2: The first read of a walk goes to address `dir_base + vaddr[31:22]*4`.
- R3: When the directory entry is present, the second read goes to address `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`. The entry layout is the same at both levels: bit 0 present, bit 1 writable, bit 2 executable, bit 5 referenced, bit 6 dirty, bits 31:12 frame number.
- R4: A clear present bit in the directory entry ends the walk after one read. A clear present bit in the table entry ends it after two reads. In both cases `fault`=1, `fault_prot`=0 and `fault_addr`=vaddr, and nothing is written.
- R5: A store to a present page whose writable bit is clear ends the walk with `fault`=1, `fault_prot`=1 and `fault_addr`=vaddr. The entry is left unwritten, with the referenced and dirty bits unchanged.
- R6: On a permitted access the table entry becomes `entry | bit5`, and on a store `entry | bit5 | bit6`. It is written back to the address of R3 in one write only if this value differs from what was read; otherwise no write occurs.
- R7: On a permitted access `fault`=0, `paddr`={entry[31:12], vaddr[11:0]}, `perm_w`=entry bit 1 and `perm_x`=entry bit 2.
- R8: The walker holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_valid` arrives. `done` is a single-cycle pulse in the cycle after the last memory transaction of the walk completes.
- R9: A `start` that arrives while `busy` is high is ignored and does not change the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken when idle) |
| vaddr | input | 32 | Virtual address to translate |
| is_store | input | 1 | Access is a store |
| dir_base | input | 32 | Byte address of the directory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended in a page fault |
| fault_prot | output | 1 | Fault is a write-protection fault |
| fault_addr | output | 32 | Virtual address that faulted |
| paddr | output | 32 | Translated physical address |
| perm_w | output | 1 | Page is writable |
| perm_x | output | 1 | Page is executable |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read |
| mem_valid | input | 1 | Transaction complete, read data valid |

## Verification
The bench memory model answers each request after a programmable number of idle cycles, L. With that model a walk of n transactions raises `done` exactly n*(L+2)-1 clock edges after the edge that accepts `start`. The bench counts edges from that accept edge and compares the count with this figure. It samples `done` and the results on the falling edge, so the registered outputs are read in the cycle they are due and never on an edge. The memory model also logs each transaction's address on the falling edge where it answers. The bench checks the address log and the final entry in the array only after the done pulse.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] vaddr,
  input  logic        is_store,
  input  logic [31:0] dir_base,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        fault_prot,
  output logic [31:0] fault_addr,
  output logic [31:0] paddr,
  output logic        perm_w,
  output logic        perm_x,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_valid
);

  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;
  localparam logic [31:0] FLAG_REF   = 32'h0000_0020;
  localparam logic [31:0] FLAG_DIRTY = 32'h0000_0040;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_WB, S_FIN} state_t;

  state_t      state;
  logic [31:0] va_q;
  logic [31:0] base_q;
  logic [19:0] tbl_frame_q;
  logic [31:0] pte_q;
  logic        store_q;
  logic        fault_q;
  logic        prot_q;
  logic [31:0] upd;

  assign upd = mem_rdata | FLAG_REF | (store_q ? FLAG_DIRTY : 32'h0);

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign mem_req    = (state == S_DIR) || (state == S_TBL) || (state == S_WB);
  assign mem_we     = (state == S_WB);
  assign mem_wdata  = pte_q;
  assign mem_addr   = (state == S_DIR) ? base_q + {20'h0, va_q[31:22], 2'b00}
                                       : {tbl_frame_q, 12'h000} + {20'h0, va_q[21:12], 2'b00};
  assign fault      = fault_q;
  assign fault_prot = prot_q;
  assign fault_addr = va_q;
  assign paddr      = {pte_q[31:12], va_q[11:0]};
  assign perm_w     = pte_q[BIT_W];
  assign perm_x     = pte_q[BIT_X];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      tbl_frame_q <= '0;
      pte_q       <= '0;
      store_q     <= 1'b0;
      fault_q     <= 1'b0;
      prot_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          va_q    <= vaddr;
          base_q  <= dir_base;
          store_q <= is_store;
          fault_q <= 1'b0;
          prot_q  <= 1'b0;
          pte_q   <= '0;
          state   <= S_DIR;
        end
        S_DIR: if (mem_valid) begin
          if (!mem_rdata[BIT_P]) begin
            fault_q <= 1'b1;
            state   <= S_FIN;
          end else begin
            tbl_frame_q <= mem_rdata[31:12];
            state       <= S_TBL;
          end
        end
        S_TBL: if (mem_valid) begin
          if (!mem_rdata[BIT_P]) begin
            pte_q   <= mem_rdata;
            fault_q <= 1'b1;
            state   <= S_FIN;
          end else if (store_q && !mem_rdata[BIT_W]) begin
            pte_q   <= mem_rdata;
            fault_q <= 1'b1;
            prot_q  <= 1'b1;
            state   <= S_FIN;
          end else begin
            pte_q <= upd;
            state <= (upd != mem_rdata) ? S_WB : S_FIN;
          end
        end
        S_WB:  if (mem_valid) state <= S_FIN;
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_WB_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[BIT_P]); // R6
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && store_q |-> mem_wdata[6]); // R6
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !fault_q); // R4
  AST_PROT_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_prot |-> fault && store_q); // R5

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_store = 1'b0;
  logic [31:0] dir_base = 32'h0000_1000;
  logic        busy, done, fault, fault_prot, perm_w, perm_x;
  logic [31:0] fault_addr, paddr;
  logic        mem_req, mem_we, mem_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .is_store(is_store),
    .dir_base(dir_base), .busy(busy), .done(done), .fault(fault),
    .fault_prot(fault_prot), .fault_addr(fault_addr), .paddr(paddr),
    .perm_w(perm_w), .perm_x(perm_x), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid)
  );

  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          cnt = 0;
  int          nrd = 0;
  int          nwr = 0;
  logic [31:0] rd_addr [0:1];
  logic [31:0] wr_addr;
  int          checks = 0;
  int          errors = 0;

  initial begin
    mem_valid = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt == lat) begin
        mem_valid = 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          wr_addr = mem_addr;
          nwr++;
        end else begin
          mem_rdata = mem[mem_addr[13:2]];
          if (nrd < 2) rd_addr[nrd] = mem_addr;
          nrd++;
        end
      end else cnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // va, pte, store, dir present, latency
  localparam logic [68:0] VEC [8] = '{
    {32'h0040_1ABC, 32'h0001_2003, 1'b0, 1'b1, 3'd0},
    {32'h0080_2010, 32'h0003_4023, 1'b1, 1'b1, 3'd1},
    {32'h00C0_3004, 32'h0005_6025, 1'b0, 1'b1, 3'd2},
    {32'h0100_4FFF, 32'h0007_8063, 1'b1, 1'b1, 3'd0},
    {32'h0140_5000, 32'h0009_A001, 1'b1, 1'b1, 3'd1},
    {32'h0180_6123, 32'h000B_C062, 1'b0, 1'b1, 3'd0},
    {32'hFFC0_7456, 32'h0000_0000, 1'b0, 1'b0, 3'd3},
    {32'hFFFF_FFFF, 32'hFFFF_F003, 1'b1, 1'b1, 3'd4}
  };

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    nrd = 0; nwr = 0; cnt = 0;
    rd_addr[0] = '0; rd_addr[1] = '0; wr_addr = '0;
  endtask

  task automatic walk(input logic [31:0] va, input logic st, input int l,
                      input logic [31:0] stray_va, input logic stray, output int cyc);
    lat = l;
    @(negedge clk);
    vaddr = va; is_store = st; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (stray && cyc == 1) begin
        vaddr = stray_va; is_store = ~st; start = 1'b1;
      end else start = 1'b0;
    end while (!done && cyc < 200);
    start = 1'b0;
    if (cyc >= 200) chk("R8 watchdog", 32'd1, 32'd0);
  endtask

  initial begin
    #10ms;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] va, pte, pde, dadr, tadr, npte;
      logic st, dp, np, prot, ok, wrote;
      int l, n;
      va = VEC[i][68:37]; pte = VEC[i][36:5]; st = VEC[i][4]; dp = VEC[i][3];
      l = int'(VEC[i][2:0]);
      pde = {20'h00002 + 20'(i & 1), 12'h001};
      dadr = dir_base + {20'h0, va[31:22], 2'b00};
      tadr = {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      clear_mem();
      mem[dadr[13:2]] = dp ? pde : 32'h0000_0000;
      if (dp) mem[tadr[13:2]] = pte;
      np    = !dp || !pte[0];
      prot  = !np && st && !pte[1];
      ok    = !np && !prot;
      npte  = ok ? (pte | 32'h20 | (st ? 32'h40 : 32'h0)) : pte;
      wrote = (npte != pte);
      n     = !dp ? 1 : (2 + int'(wrote));
      walk(va, st, l, 32'h0, 1'b0, cyc);
      chk($sformatf("R8 latency v%0d", i), 32'(cyc), 32'(n * (l + 2) - 1));
      chk($sformatf("R2 dir addr v%0d", i), rd_addr[0], dadr);
      chk($sformatf("R4 fault v%0d", i), {31'd0, fault}, {31'd0, !ok});
      chk($sformatf("R5 prot v%0d", i), {31'd0, fault_prot}, {31'd0, prot});
      chk($sformatf("R6 writes v%0d", i), 32'(nwr), 32'(int'(wrote)));
      if (dp) begin
        chk($sformatf("R3 tbl addr v%0d", i), rd_addr[1], tadr);
        chk($sformatf("R6 entry v%0d", i), mem[tadr[13:2]], npte);
        if (wrote) chk($sformatf("R6 wb addr v%0d", i), wr_addr, tadr);
      end else chk($sformatf("R4 dir-only reads v%0d", i), 32'(nrd), 32'd1);
      if (!ok) chk($sformatf("R4 fault addr v%0d", i), fault_addr, va);
      else begin
        chk($sformatf("R7 paddr v%0d", i), paddr, {pte[31:12], va[11:0]});
        chk($sformatf("R7 perms v%0d", i), {30'd0, perm_w, perm_x}, {30'd0, pte[1], pte[2]});
      end
      @(negedge clk);
      chk($sformatf("R8 done pulse v%0d", i), {31'd0, done}, 32'd0);
    end

    begin
      logic [31:0] va, tadr;
      va = 32'h0200_9345;
      clear_mem();
      mem[(dir_base[13:2]) + 12'(va[31:22])] = 32'h0000_2001;
      tadr = 32'h0000_2000 + {20'h0, va[21:12], 2'b00};
      mem[tadr[13:2]] = 32'h0004_4001;
      walk(va, 1'b0, 2, 32'h0300_0777, 1'b1, cyc);
      chk("R9 paddr kept", paddr, 32'h0004_4345);
      chk("R9 latency", 32'(cyc), 32'd11);
      chk("R9 reads", 32'(nrd), 32'd2);
      chk("R9 entry", mem[tadr[13:2]], 32'h0004_4021);
      repeat (3) @(negedge clk);
      chk("R9 no second walk", {30'd0, busy, mem_req}, 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule